// File: doc/BRIEF.md
# Per-Pixel Plane-Select Colour Fetch

This block scans a frame buffer that is kept as three parallel planes: an 8-bit index plane, a 32-bit true-colour plane and a 32-bit control plane. All three share one word address per pixel. For every pixel the block issues one address to all three planes, then reads the control word back. The top byte of that word decides whether the pixel shows the true-colour value directly or the palette entry picked by the 8-bit index. The result is one 24-bit RGB pixel per clock, with a valid flag, in raster order.

A frame scan begins with a one-cycle start pulse. The active width and height are sampled at that pulse. Lines are always laid out 1024 words apart, whatever the active width. The plane memories and the palette memory sit outside the block. Each returns read data one cycle after its address. A one-cycle done pulse follows the last pixel of the frame.

The control sits in a three-state machine. IDLE waits for start. IDLE goes to SCAN on a start pulse with nonzero width and height; a start with a zero dimension leaves the machine in IDLE. SCAN issues one address per clock and goes to DRAIN after the last pixel's address. DRAIN waits while the pipeline empties and returns to IDLE on the done pulse.

Top module: `plane_pixel_mixer`

## Requirements
- R1: After reset, rd_en, pal_rd_en, out_valid and done are all 0 and stay 0 until a valid start pulse.
- R2: A start pulse in IDLE with nonzero act_w and act_h issues plane reads on consecutive clocks for pixels (0,0), (1,0) … in raster order, with x fastest. One read is issued per clock and the scan covers exactly width × height pixels.
- R3: The plane word address of pixel (x,y) is y*1024 + x for any active width, so line starts are 1024 words apart.
- R4: When control bits 31:24 equal 8'h03, the output colour is the true-colour word's bits 23:16 on out_r, bits 15:8 on out_g and bits 7:0 on out_b. The true-colour word's bits 31:24 have no effect.
- R5: For any other control top-byte value, pal_addr carries the 8-bit index one clock after the plane read, with pal_rd_en high. The output colour is the palette data returned one clock later, split as bits 23:16 = R, 15:8 = G, 7:0 = B.
- R6: out_valid for a pixel rises exactly 3 clocks after its rd_en cycle. Both colour paths share this latency, and a frame's pixels leave on consecutive clocks.
- R7: done is a single-cycle pulse raised in the clock after the out_valid of the frame's last pixel.
- R8: A start pulse while a scan or drain is in progress is ignored: the address sequence and pixel count of the running frame are unchanged.
- R9: A start pulse with act_w = 0 or act_h = 0 is ignored: no read is issued and no done is raised.
- R10: act_w above 1024 is taken as 1024 and act_h above 768 is taken as 768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a frame scan |
| act_w | input | 11 | Active width in pixels, sampled at start |
| act_h | input | 10 | Active height in lines, sampled at start |
| rd_en | output | 1 | Plane read strobe, one per pixel |
| rd_addr | output | 20 | Plane word address y*1024 + x |
| idx_data | input | 8 | Index plane read data, one clock after rd_en |
| tc_data | input | 32 | True-colour plane read data, one clock after rd_en |
| ctl_data | input | 32 | Control plane read data, one clock after rd_en |
| pal_rd_en | output | 1 | Palette read strobe |
| pal_addr | output | 8 | Palette index |
| pal_data | input | 24 | Palette entry {R,G,B}, one clock after pal_addr |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 8 | Red |
| out_g | output | 8 | Green |
| out_b | output | 8 | Blue |
| done | output | 1 | Frame-complete pulse |

## Verification
A wrong x, y or line-base register shows at once on rd_addr, in the cycle the bad pixel is issued. Through the plane models it then shows as a wrong colour three clocks later. A stuck or misrouted select flag shows three clocks after the affected read as a colour from the wrong path, because the control pattern mixes direct and palette pixels within every line and uses top bytes that differ from 8'h03 only in single bit groups. A machine that leaves SCAN early or late shows as a wrong pixel count, and a misplaced done pulse is measured against the last valid cycle.

// File: rtl/pps_pkg.sv
package pps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_DRAIN = 2'd2
    } scan_state_e;

    // control top-byte value that selects the true-colour path
    localparam logic [7:0] DIRECT_TAG = 8'h03;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

endpackage

// File: rtl/pps_scan_fsm.sv
module pps_scan_fsm
    import pps_pkg::*;
#(
    parameter int MAX_W  = 1024,
    parameter int MAX_H  = 768,
    parameter int STRIDE = 1024,
    parameter int WW     = 11,
    parameter int HW     = 10,
    parameter int AW     = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [WW-1:0] cfg_w,
    input  logic [HW-1:0] cfg_h,
    input  logic          frame_done,
    output logic          rd_en,
    output logic          rd_last,
    output logic [AW-1:0] rd_addr
);

    localparam logic [31:0] PLANE_WORDS = 32'(STRIDE * MAX_H);

    scan_state_e   st, st_nxt;
    logic [WW-1:0] wl, x;
    logic [HW-1:0] hl, y;
    logic [AW-1:0] addr_q, base_q;
    logic [WW-1:0] cw;
    logic [HW-1:0] ch;
    logic          launch, eol, eof;

    assign cw     = (cfg_w > WW'(MAX_W)) ? WW'(MAX_W) : cfg_w;
    assign ch     = (cfg_h > HW'(MAX_H)) ? HW'(MAX_H) : cfg_h;
    assign launch = (st == ST_IDLE) && start && (cfg_w != '0) && (cfg_h != '0);
    assign eol    = (x == wl - 1'b1);
    assign eof    = eol && (y == hl - 1'b1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:  if (launch)     st_nxt = ST_SCAN;
            ST_SCAN:  if (eof)        st_nxt = ST_DRAIN;
            ST_DRAIN: if (frame_done) st_nxt = ST_IDLE;
            default:                  st_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_en   = (st == ST_SCAN);
        rd_last = (st == ST_SCAN) && eof;
        rd_addr = addr_q;
    end

    // coordinate and address counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wl     <= '0;
            hl     <= '0;
            x      <= '0;
            y      <= '0;
            addr_q <= '0;
            base_q <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (launch) begin
                        wl     <= cw;
                        hl     <= ch;
                        x      <= '0;
                        y      <= '0;
                        addr_q <= '0;
                        base_q <= '0;
                    end
                end
                ST_SCAN: begin
                    if (!eof) begin
                        if (eol) begin
                            x      <= '0;
                            y      <= y + 1'b1;
                            base_q <= base_q + AW'(STRIDE);
                            addr_q <= base_q + AW'(STRIDE);
                        end else begin
                            x      <= x + 1'b1;
                            addr_q <= addr_q + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !eol) |=> (rd_en && rd_addr == $past(rd_addr) + 1'b1));

    // R3
    line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && eol && !eof) |=> (rd_en && rd_addr == $past(base_q) + AW'(STRIDE)));

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DRAIN && start) |=> (st != ST_SCAN));

    // R9
    zero_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && start && (cfg_w == '0 || cfg_h == '0)) |=> (st == ST_IDLE));

    // R10
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> ({{(32-AW){1'b0}}, rd_addr} < PLANE_WORDS));

endmodule

// File: rtl/pps_plane_sel.sv
module pps_plane_sel
    import pps_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_en,
    input  logic        rd_last,
    input  logic [7:0]  idx_in,
    input  logic [31:0] tc_in,
    input  logic [31:0] ctl_in,
    output logic        pal_rd_en,
    output logic [7:0]  pal_addr,
    output logic        s2_valid,
    output logic        s2_last,
    output logic        s2_direct,
    output rgb_t        s2_rgb
);

    logic m1_valid, m1_last;

    // align the pixel tag with plane data arriving one clock after the read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m1_valid <= 1'b0;
            m1_last  <= 1'b0;
        end else begin
            m1_valid <= rd_en;
            m1_last  <= rd_last;
        end
    end

    assign pal_rd_en = m1_valid;
    assign pal_addr  = idx_in;

    // decide the path; delay the true colour to meet the palette return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid  <= 1'b0;
            s2_last   <= 1'b0;
            s2_direct <= 1'b0;
            s2_rgb    <= '0;
        end else begin
            s2_valid  <= m1_valid;
            s2_last   <= m1_last;
            s2_direct <= m1_valid && (ctl_in[31:24] == DIRECT_TAG);
            s2_rgb    <= tc_in[23:0];
        end
    end

    // R5
    pal_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pal_rd_en |-> $past(rd_en));

endmodule

// File: rtl/pps_out_stage.sv
module pps_out_stage
    import pps_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        s2_valid,
    input  logic        s2_last,
    input  logic        s2_direct,
    input  rgb_t        s2_rgb,
    input  logic [23:0] pal_data,
    output logic        out_valid,
    output rgb_t        out_pix,
    output logic        done
);

    logic out_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_pix   <= '0;
            done      <= 1'b0;
        end else begin
            out_valid <= s2_valid;
            out_last  <= s2_valid && s2_last;
            out_pix   <= s2_direct ? s2_rgb : rgb_t'(pal_data);
            done      <= out_valid && out_last;
        end
    end

    // R7
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_valid && out_last));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/plane_pixel_mixer.sv
module plane_pixel_mixer
    import pps_pkg::*;
#(
    parameter int MAX_W  = 1024,
    parameter int MAX_H  = 768,
    parameter int STRIDE = 1024,
    localparam int WW    = $clog2(MAX_W + 1),
    localparam int HW    = $clog2(MAX_H + 1),
    localparam int AW    = $clog2(STRIDE * MAX_H)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [WW-1:0] act_w,
    input  logic [HW-1:0] act_h,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    idx_data,
    input  logic [31:0]   tc_data,
    input  logic [31:0]   ctl_data,
    output logic          pal_rd_en,
    output logic [7:0]    pal_addr,
    input  logic [23:0]   pal_data,
    output logic          out_valid,
    output logic [7:0]    out_r,
    output logic [7:0]    out_g,
    output logic [7:0]    out_b,
    output logic          done
);

    logic rd_last, s2_valid, s2_last, s2_direct;
    rgb_t s2_rgb, pix;

    pps_scan_fsm #(
        .MAX_W(MAX_W), .MAX_H(MAX_H), .STRIDE(STRIDE),
        .WW(WW), .HW(HW), .AW(AW)
    ) u_scan (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_w(act_w), .cfg_h(act_h), .frame_done(done),
        .rd_en(rd_en), .rd_last(rd_last), .rd_addr(rd_addr)
    );

    pps_plane_sel u_sel (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_last(rd_last),
        .idx_in(idx_data), .tc_in(tc_data), .ctl_in(ctl_data),
        .pal_rd_en(pal_rd_en), .pal_addr(pal_addr),
        .s2_valid(s2_valid), .s2_last(s2_last),
        .s2_direct(s2_direct), .s2_rgb(s2_rgb)
    );

    pps_out_stage u_out (
        .clk(clk), .rst_n(rst_n), .s2_valid(s2_valid), .s2_last(s2_last),
        .s2_direct(s2_direct), .s2_rgb(s2_rgb), .pal_data(pal_data),
        .out_valid(out_valid), .out_pix(pix), .done(done)
    );

    assign out_r = pix.r;
    assign out_g = pix.g;
    assign out_b = pix.b;

    // R4
    direct_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(ctl_data[31:24], 2) == DIRECT_TAG)
            |-> ({out_r, out_g, out_b} == $past(tc_data[23:0], 2)));

    // R5
    palette_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(ctl_data[31:24], 2) != DIRECT_TAG)
            |-> ({out_r, out_g, out_b} == $past(pal_data)));

    // R6
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(rd_en, 3));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en) |-> $past(start));

endmodule

// File: tb/plane_pixel_mixer_bench.sv
module plane_pixel_mixer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [10:0] act_w = '0;
    logic [9:0]  act_h = '0;
    logic        rd_en, pal_rd_en, out_valid, done;
    logic [19:0] rd_addr;
    logic [7:0]  pal_addr, out_r, out_g, out_b;
    logic [7:0]  idx_d;
    logic [31:0] tc_d, ctl_d;
    logic [23:0] pal_d;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    plane_pixel_mixer u_plane_pixel_mixer (
        .clk(clk), .rst_n(rst_n), .start(start), .act_w(act_w), .act_h(act_h),
        .rd_en(rd_en), .rd_addr(rd_addr), .idx_data(idx_d), .tc_data(tc_d),
        .ctl_data(ctl_d), .pal_rd_en(pal_rd_en), .pal_addr(pal_addr),
        .pal_data(pal_d), .out_valid(out_valid), .out_r(out_r), .out_g(out_g),
        .out_b(out_b), .done(done)
    );

    // plane and palette contents, computed from the address
    function automatic logic [7:0] idx_f(int a);
        return 8'((a * 7) + ((a >> 10) * 13) + 5);
    endfunction
    function automatic logic [31:0] tc_f(int a);
        logic [31:0] t;
        t = 32'(a) * 32'd40503;
        return {t[31:24] ^ 8'hC3, t[23:0] ^ 24'(a)};
    endfunction
    function automatic logic [31:0] ctl_f(int a);
        logic [7:0] top;
        case (a % 6)
            0: top = 8'h03;
            1: top = 8'h00;
            2: top = 8'h03;
            3: top = 8'h0B;
            4: top = 8'h02;
            default: top = 8'h83;
        endcase
        return {top, 24'(a * 3)};
    endfunction
    function automatic logic [23:0] pal_f(logic [7:0] i);
        return {i, ~i, i + 8'h35};
    endfunction
    function automatic logic [23:0] exp_pix(int x, int y);
        int a;
        a = y * 1024 + x;
        if (ctl_f(a)[31:24] == 8'h03) return tc_f(a)[23:0];
        return pal_f(idx_f(a));
    endfunction

    // memory models with one clock of read latency
    always @(posedge clk) begin
        cyc   <= cyc + 1;
        idx_d <= idx_f(int'(rd_addr));
        tc_d  <= tc_f(int'(rd_addr));
        ctl_d <= ctl_f(int'(rd_addr));
        pal_d <= pal_f(pal_addr);
    end

    // monitor state
    int cur_w = 1, cur_h = 1;
    int ix = 0, iy = 0, ox = 0, oy = 0;
    int n_rd = 0, n_out = 0, n_done = 0;
    int last_cyc = -10, done_cyc = -10;
    logic [2:0] hist = '0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            // R6: valid exactly three clocks after the read
            if (hist[2] || out_valid)
                check(out_valid == hist[2], "R6", "out_valid latency", out_valid, hist[2]);
            hist = {hist[1:0], rd_en};
            if (rd_en) begin
                // R2 R3: raster order and 1024-word stride
                check(int'(rd_addr) == iy * 1024 + ix, "R3", "rd_addr",
                      int'(rd_addr), iy * 1024 + ix);
                n_rd++;
                if (ix == cur_w - 1) begin ix = 0; iy++; end else ix++;
            end
            if (out_valid) begin
                // R4 R5: colour from the selected path
                check({out_r, out_g, out_b} == exp_pix(ox, oy),
                      (ctl_f(oy * 1024 + ox)[31:24] == 8'h03) ? "R4" : "R5",
                      "pixel", int'({out_r, out_g, out_b}), int'(exp_pix(ox, oy)));
                n_out++;
                if (n_out == cur_w * cur_h) last_cyc = cyc;
                if (ox == cur_w - 1) begin ox = 0; oy++; end else ox++;
            end
            if (done) begin
                n_done++;
                done_cyc = cyc;
            end
        end
    end

    task automatic run_frame(int w, int h, int ew, int eh, bit mid_start);
        int guard;
        cur_w = ew; cur_h = eh;
        ix = 0; iy = 0; ox = 0; oy = 0;
        n_rd = 0; n_out = 0; n_done = 0;
        @(negedge clk);
        act_w = 11'(w); act_h = 10'(h); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (mid_start) begin
            repeat (3) @(negedge clk);
            act_w = 11'd2; act_h = 10'd1; start = 1'b1;   // R8
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (n_done == 0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
        check(n_rd == ew * eh, mid_start ? "R8" : "R2", "read count", n_rd, ew * eh);
        check(n_out == ew * eh, (w > 1024 || h > 768) ? "R10" : "R2", "pixel count",
              n_out, ew * eh);
        check(n_done == 1, "R7", "done pulses", n_done, 1);
        check(done_cyc == last_cyc + 1, "R7", "done cycle", done_cyc, last_cyc + 1);
    endtask

    task automatic ignored_start(int w, int h);
        int r0, d0;
        r0 = n_rd; d0 = n_done;
        @(negedge clk);
        act_w = 11'(w); act_h = 10'(h); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        check(n_rd == r0, "R9", "reads after zero-size start", n_rd, r0);
        check(n_done == d0, "R9", "done after zero-size start", n_done, d0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(rd_en == 1'b0, "R1", "rd_en", rd_en, 0);
        check(pal_rd_en == 1'b0, "R1", "pal_rd_en", pal_rd_en, 0);
        check(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
        check(done == 1'b0, "R1", "done", done, 0);
        repeat (5) @(negedge clk);
        check(rd_en == 1'b0 && out_valid == 1'b0, "R1", "quiet without start", rd_en, 0);

        run_frame(5, 3, 5, 3, 1'b0);
        run_frame(1, 1, 1, 1, 1'b0);
        run_frame(1, 4, 1, 4, 1'b0);
        run_frame(7, 1, 7, 1, 1'b0);
        run_frame(12, 6, 12, 6, 1'b0);
        run_frame(6, 4, 6, 4, 1'b1);
        ignored_start(0, 5);
        ignored_start(4, 0);
        run_frame(2, 2, 2, 2, 1'b0);
        run_frame(1100, 1, 1024, 1, 1'b0);
        run_frame(1, 800, 1, 768, 1'b0);
        run_frame(3, 5, 3, 5, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule